// File: doc/BRIEF.md
# Serial Paged Register Port

This block lets an external host reach byte-wide internal registers over a four-wire SPI link (mode 0, MSB first) with one extra handshake line. It oversamples the slave select, serial clock and MOSI in the core clock domain. Each select frame opens with a command byte. The top bit of that byte picks read or write. The lower seven bits give an offset inside a 128-byte page. The full internal address is the externally supplied page number placed above that offset.

After the command byte, any number of data bytes may follow in the same frame. With increments enabled, each data byte moves one register further and wraps inside the page. With increments disabled, every byte goes to the same register. For reads, the block fetches the next register during the enforced byte gap and has it ready in the shift register before the host clocks again.

The ready output tells the host when the next byte or frame may start. It stays low for a start-up window after reset, for a short pause after each byte, for a recovery pause after each deselect, and while a framing fault is flagged.

Top module: `spi_paged_regport`

## Requirements
- R1: While reset is held low, `rdy`, `reg_wr`, `reg_rd`, `spi_err` and `miso` are all 0.
- R2: After reset is released, `rdy` stays low for 1100 core clocks. A frame whose select falls in that window is ignored and produces no register access.
- R3: In the command byte, bit 7 set to 1 means read and 0 means write. Bits 6..0 are the offset. `reg_addr` is `{page, offset}`, with the page in the upper bits.
- R4: In a write frame, each complete data byte after the command produces exactly one single-cycle `reg_wr` pulse, with that byte on `reg_wdata`. No other write is ever issued.
- R5: With `incr_en` = 1, successive data bytes in a frame use offset+1, offset+2 and so on, and offset 127 wraps to 0 within the same page. With `incr_en` = 0, every data byte uses the command offset.
- R6: In a read frame, each data byte returns the register content on MISO, MSB first. MISO is valid at each rising SCLK edge, and the data from MOSI is ignored (no write).
- R7: After each complete byte in an accepted frame, `rdy` is low for exactly 5 core clocks in a write frame and 14 core clocks in a read frame.
- R8: After select is released, `rdy` is low for exactly 4 core clocks. A frame whose select falls while `rdy` is low is ignored: no access and no error.
- R9: A rising SCLK edge during the byte gap raises `spi_err`. The rest of the frame is then discarded (no further read or write), and `rdy` stays low. `spi_err` clears when the post-deselect pause ends.
- R10: A frame released after 1 to 7 bits of a byte issues no access for that byte. It raises `spi_err` until the post-deselect pause ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ssel_n | input | 1 | SPI slave select, active low, asynchronous |
| sclk | input | 1 | SPI serial clock, asynchronous |
| mosi | input | 1 | SPI data from host |
| miso | output | 1 | SPI data to host |
| rdy | output | 1 | Host may start the next byte or frame |
| spi_err | output | 1 | Framing fault flag |
| incr_en | input | 1 | 1: address advances per data byte |
| page | input | PAGE_W | Page number joined above the offset |
| reg_addr | output | PAGE_W+7 | Register address |
| reg_wr | output | 1 | Register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rd | output | 1 | Register read strobe |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_rd` |

## Verification
The hardest conditions to reach are the faults: an SCLK edge arriving inside the byte gap, and a select pulse that returns before the recovery pause ends. A well-behaved host waits for `rdy` and never produces either one. The bench therefore has frames that skip the ready wait on purpose. In one, a data byte is clocked straight after a read command. In another, the bench deselects after three bits. In a third, it reselects one clock after deselect. A per-clock write model checks that none of these frames leaks a register access.

// File: rtl/spi_pra_pkg.sv
// Shared types for the serial paged register port.
package spi_pra_pkg;
    // Frame phase: idle, expecting command byte, data bytes, or discarding.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_DATA = 2'd2,
        PH_SKIP = 2'd3
    } phase_t;
endpackage

// File: rtl/spi_pra_sync.sv
// Multi-bit input synchronizer.
// Each bit passes through its own flop chain into the core clock domain.
// Assumes the bits are unrelated asynchronous levels; the reset value per bit
// is given so that idle levels are seen during reset.
module spi_pra_sync #(
    parameter int N = 3,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the raw level through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], async_i[g]};
        end
        assign sync_o[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_pra_shifter.sv
// Byte shifter for SPI mode 0.
// Receive: samples MOSI on each synchronized rising SCLK edge and reports a
// complete byte combinationally on the edge that delivers its last bit.
// Transmit: MISO is the MSB of a shift register that advances on falling
// edges inside a byte, and can be parallel-loaded between bytes.
// Assumes rise/fall strobes are single-cycle and never coincide.
module spi_pra_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         rise_i,
    input  logic         fall_i,
    input  logic         mosi_i,
    input  logic         load_i,
    input  logic [W-1:0] load_data_i,
    output logic [W-1:0] rx_byte_o,
    output logic         byte_done_o,
    output logic         partial_o,
    output logic         miso_o
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] bit_cnt;
    logic [W-1:0]  rx_sr;
    logic [W-1:0]  tx_sr;

    assign rx_byte_o   = {rx_sr[W-2:0], mosi_i};
    assign byte_done_o = rise_i && (bit_cnt == LAST);
    assign partial_o   = (bit_cnt != '0);
    assign miso_o      = tx_sr[W-1];

    // Count received bits and collect them MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
        end else if (rise_i) begin
            bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + CW'(1);
            rx_sr   <= {rx_sr[W-2:0], mosi_i};
        end
    end

    // Hold, load or advance the outgoing byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)           tx_sr <= '0;
        else if (load_i)                 tx_sr <= load_data_i;
        else if (fall_i && partial_o)    tx_sr <= {tx_sr[W-2:0], 1'b0};
    end

    // R6
    miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_i && !load_i && !clear_i) |=> $stable(miso_o));
endmodule

// File: rtl/spi_pra_timer.sv
// Handshake timing for the port.
// Three down/up counters in core clocks: the start-up window after reset,
// the pause after each byte (length chosen by direction), and the recovery
// pause after deselect. Assumes loads are single-cycle strobes.
module spi_pra_timer #(
    parameter int STARTUP_CYC = 1100,
    parameter int GAP_WR = 5,
    parameter int GAP_RD = 14,
    parameter int IDLE_GAP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gap_load_i,
    input  logic gap_rd_i,
    input  logic idle_load_i,
    output logic startup_done_o,
    output logic gap_busy_o,
    output logic idle_busy_o,
    output logic idle_last_o
);
    localparam int GAP_MAX = (GAP_RD > GAP_WR) ? GAP_RD : GAP_WR;
    localparam int SW = $clog2(STARTUP_CYC + 1);
    localparam int GW = $clog2(GAP_MAX + 1);
    localparam int IW = $clog2(IDLE_GAP + 1);

    logic [SW-1:0] start_cnt;
    logic [GW-1:0] gap_cnt;
    logic [IW-1:0] idle_cnt;

    assign startup_done_o = (start_cnt == SW'(STARTUP_CYC));
    assign gap_busy_o     = (gap_cnt != '0);
    assign idle_busy_o    = (idle_cnt != '0);
    assign idle_last_o    = (idle_cnt == IW'(1));

    // Count up once after reset until the start-up window is over.
    always_ff @(posedge clk) begin
        if (!rst_n)               start_cnt <= '0;
        else if (!startup_done_o) start_cnt <= start_cnt + SW'(1);
    end

    // Inter-byte pause counter.
    always_ff @(posedge clk) begin
        if (!rst_n)          gap_cnt <= '0;
        else if (gap_load_i) gap_cnt <= gap_rd_i ? GW'(GAP_RD) : GW'(GAP_WR);
        else if (gap_busy_o) gap_cnt <= gap_cnt - GW'(1);
    end

    // Post-deselect recovery counter.
    always_ff @(posedge clk) begin
        if (!rst_n)           idle_cnt <= '0;
        else if (idle_load_i) idle_cnt <= IW'(IDLE_GAP);
        else if (idle_busy_o) idle_cnt <= idle_cnt - IW'(1);
    end

    // R8
    idle_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_last_o && !idle_load_i) |=> !idle_busy_o);
endmodule

// File: rtl/spi_paged_regport.sv
// Serial paged register port, top level.
// Decodes SPI select frames into byte-wide register accesses. The command
// byte carries direction (bit 7) and page offset; data bytes follow with an
// optional address increment. Read data is prefetched during the byte gap.
// Assumes SCLK, SSEL and MOSI change slowly relative to clk (at least a few
// core clocks per SCLK phase) and that reg_rdata is valid one cycle after
// reg_rd.
module spi_paged_regport
    import spi_pra_pkg::*;
#(
    parameter int PAGE_W = 4,
    parameter int BYTE_W = 8,
    parameter int STARTUP_CYC = 1100,
    parameter int GAP_WR = 5,
    parameter int GAP_RD = 14,
    parameter int IDLE_GAP = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ssel_n,
    input  logic                        sclk,
    input  logic                        mosi,
    output logic                        miso,
    output logic                        rdy,
    output logic                        spi_err,
    input  logic                        incr_en,
    input  logic [PAGE_W-1:0]           page,
    output logic [PAGE_W+BYTE_W-2:0]    reg_addr,
    output logic                        reg_wr,
    output logic [BYTE_W-1:0]           reg_wdata,
    output logic                        reg_rd,
    input  logic [BYTE_W-1:0]           reg_rdata
);
    localparam int OFF_W = BYTE_W - 1;
    localparam int AW = PAGE_W + OFF_W;

    // Synchronized pins: bit 0 select, bit 1 clock, bit 2 data.
    logic [2:0] pins_s;
    logic       s_ssel_n, s_sclk, s_mosi;
    logic       ssel_d, sclk_d;
    logic       sclk_rise, sclk_fall, sel_fall, sel_rise;

    spi_pra_sync #(
        .N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({mosi, sclk, ssel_n}),
        .sync_o(pins_s)
    );

    assign s_ssel_n = pins_s[0];
    assign s_sclk   = pins_s[1];
    assign s_mosi   = pins_s[2];

    // Remember previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ssel_d <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            ssel_d <= s_ssel_n;
            sclk_d <= s_sclk;
        end
    end

    assign sclk_rise = s_sclk & ~sclk_d;
    assign sclk_fall = ~s_sclk & sclk_d;
    assign sel_fall  = ~s_ssel_n & ssel_d;
    assign sel_rise  = s_ssel_n & ~ssel_d;

    // Frame control state.
    phase_t              phase;
    logic                dir_rd_q;
    logic [OFF_W-1:0]    off_q;
    logic [AW-1:0]       addr_q;
    logic                wr_q, rd_q, ld_q, err_q;
    logic [BYTE_W-1:0]   wdata_q;

    logic [BYTE_W-1:0]   rx_byte;
    logic                byte_done, partial;
    logic                startup_done, gap_busy, idle_busy, idle_last;
    logic                in_frame, ready, violation, gap_load, gap_rd;
    logic [OFF_W-1:0]    nxt_off;

    assign in_frame  = (phase == PH_CMD) || (phase == PH_DATA);
    assign ready     = startup_done & ~gap_busy & ~idle_busy & ~err_q;
    assign violation = in_frame && sclk_rise && gap_busy;
    assign gap_load  = in_frame && byte_done && !violation && !sel_rise;
    assign gap_rd    = (phase == PH_CMD) ? rx_byte[BYTE_W-1] : dir_rd_q;
    assign nxt_off   = incr_en ? off_q + OFF_W'(1) : off_q;

    spi_pra_shifter #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .clear_i(sel_fall),
        .rise_i(sclk_rise),
        .fall_i(sclk_fall),
        .mosi_i(s_mosi),
        .load_i(ld_q),
        .load_data_i(reg_rdata),
        .rx_byte_o(rx_byte),
        .byte_done_o(byte_done),
        .partial_o(partial),
        .miso_o(miso)
    );

    spi_pra_timer #(
        .STARTUP_CYC(STARTUP_CYC), .GAP_WR(GAP_WR),
        .GAP_RD(GAP_RD), .IDLE_GAP(IDLE_GAP)
    ) u_timer (
        .clk(clk), .rst_n(rst_n),
        .gap_load_i(gap_load),
        .gap_rd_i(gap_rd),
        .idle_load_i(sel_rise),
        .startup_done_o(startup_done),
        .gap_busy_o(gap_busy),
        .idle_busy_o(idle_busy),
        .idle_last_o(idle_last)
    );

    // Frame sequencing: command decode, access issue, fault capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            dir_rd_q <= 1'b0;
            off_q    <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            wr_q     <= 1'b0;
            rd_q     <= 1'b0;
            ld_q     <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
            ld_q <= rd_q;
            if (idle_last && phase == PH_IDLE) err_q <= 1'b0;
            if (sel_rise) begin
                if (in_frame && partial) err_q <= 1'b1;
                phase <= PH_IDLE;
            end else if (sel_fall) begin
                phase <= ready ? PH_CMD : PH_SKIP;
            end else if (violation) begin
                err_q <= 1'b1;
                phase <= PH_SKIP;
            end else if (in_frame && byte_done) begin
                if (phase == PH_CMD) begin
                    dir_rd_q <= rx_byte[BYTE_W-1];
                    off_q    <= rx_byte[OFF_W-1:0];
                    phase    <= PH_DATA;
                    if (rx_byte[BYTE_W-1]) begin
                        rd_q   <= 1'b1;
                        addr_q <= {page, rx_byte[OFF_W-1:0]};
                    end
                end else if (dir_rd_q) begin
                    rd_q   <= 1'b1;
                    addr_q <= {page, nxt_off};
                    off_q  <= nxt_off;
                end else begin
                    wr_q    <= 1'b1;
                    wdata_q <= rx_byte;
                    addr_q  <= {page, off_q};
                    off_q   <= nxt_off;
                end
            end
        end
    end

    assign rdy       = ready;
    assign spi_err   = err_q;
    assign reg_addr  = addr_q;
    assign reg_wr    = wr_q;
    assign reg_wdata = wdata_q;
    assign reg_rd    = rd_q;

    // R4
    wr_from_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $past(byte_done));
    // R6
    load_in_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_q |-> gap_busy);
    // R2
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CMD) |-> startup_done);
    // R8
    desel_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rise |=> !rdy);
    // R9
    err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_err |-> !reg_wr);
endmodule

// File: tb/spi_paged_regport_bench.sv
// Bench: behavioural register file and write-expectation queue, checked
// every clock; SPI host driven by tasks.
module spi_paged_regport_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PAGE_W = 4;
    localparam int AW = PAGE_W + 7;
    localparam int HALF = 4;
    localparam int GAP_WR = 5;
    localparam int GAP_RD = 14;
    localparam int IDLE_GAP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ssel_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic incr_en = 1'b1;
    logic [PAGE_W-1:0] page = '0;
    logic miso, rdy, spi_err, reg_wr, reg_rd;
    logic [AW-1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata = '0;

    int n_chk = 0, n_fail = 0;
    int rd_cnt = 0, low_run = 0, last_low = 0;
    bit finished = 0;
    logic [7:0] mem [0:(1<<AW)-1];
    int exp_addr[$];
    int exp_data[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_paged_regport u_spi_paged_regport (
        .clk(clk), .rst_n(rst_n), .ssel_n(ssel_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .rdy(rdy), .spi_err(spi_err), .incr_en(incr_en),
        .page(page), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Register file model: write, and read data one cycle after the strobe.
    initial for (int i = 0; i < (1<<AW); i++) mem[i] = 8'(i * 7 + 3);
    always @(posedge clk) begin
        if (reg_wr) mem[reg_addr] <= reg_wdata;
        if (reg_rd) reg_rdata <= mem[reg_addr];
    end

    // Per-clock comparison of writes and tracking of ready runs.
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr) begin
                if (exp_addr.size() == 0)
                    chk(0, "R4", "unexpected write", {reg_addr, reg_wdata}, 0);
                else begin
                    int a, d;
                    a = exp_addr.pop_front();
                    d = exp_data.pop_front();
                    chk(reg_addr == AW'(a) && reg_wdata == 8'(d), "R4",
                        "write addr/data", {reg_addr, reg_wdata}, (a << 8) | d);
                end
            end
            if (reg_rd) rd_cnt++;
            if (!rdy) low_run++;
            else if (low_run != 0) begin
                last_low = low_run;
                low_run = 0;
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rdy();
        int t = 0;
        while (!rdy && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 5000) chk(0, "R7", "ready timeout", 0, 1);
        tick(1);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            tick(HALF);
            sclk = 1'b1;
            rx[i] = miso;
            tick(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic sel();
        ssel_n = 1'b0;
        tick(4);
    endtask

    task automatic desel_check();
        ssel_n = 1'b1;
        tick(4);
        wait_rdy();
        chk(last_low == IDLE_GAP, "R8", "post-deselect pause", last_low, IDLE_GAP);
    endtask

    function automatic int off_at(input int off, input int k);
        return incr_en ? ((off + k) % 128) : off;
    endfunction

    task automatic wframe(input int off, input int n, input int base);
        logic [7:0] rx;
        sel();
        xfer(8'(off), rx);
        for (int k = 0; k < n; k++) begin
            wait_rdy();
            chk(last_low == GAP_WR, "R7", "write gap", last_low, GAP_WR);
            exp_addr.push_back((int'(page) << 7) | off_at(off, k));
            exp_data.push_back((base + k * 17) & 8'hFF);
            xfer(8'((base + k * 17) & 8'hFF), rx);
        end
        wait_rdy();
        desel_check();
    endtask

    task automatic rframe(input int off, input int n, input string req);
        logic [7:0] rx;
        sel();
        xfer(8'(8'h80 | off), rx);
        for (int k = 0; k < n; k++) begin
            int e;
            wait_rdy();
            chk(last_low == GAP_RD, "R7", "read gap", last_low, GAP_RD);
            e = mem[(int'(page) << 7) | off_at(off, k)];
            xfer(8'hFF, rx);
            chk(rx == 8'(e), req, "read byte", rx, e);
        end
        wait_rdy();
        desel_check();
    endtask

    initial begin
        logic [7:0] rx;
        int rc;
        tick(3);
        // R1: reset state
        chk(rdy == 0, "R1", "rdy in reset", rdy, 0);
        chk(reg_wr == 0 && reg_rd == 0, "R1", "strobes in reset", {reg_wr, reg_rd}, 0);
        chk(spi_err == 0, "R1", "err in reset", spi_err, 0);
        chk(miso == 0, "R1", "miso in reset", miso, 0);
        rst_n = 1'b1;
        // R2: frame during start-up ignored
        tick(50);
        sel();
        xfer(8'h05, rx);
        tick(20);
        xfer(8'h11, rx);
        tick(20);
        ssel_n = 1'b1;
        tick(1095 - 50 - 4 - 128 - 40);
        chk(rdy == 0, "R2", "rdy before start-up end", rdy, 0);
        tick(15);
        chk(rdy == 1, "R2", "rdy after start-up", rdy, 1);
        chk(spi_err == 0, "R2", "no error for early frame", spi_err, 0);
        // R3 R4 R5 R6: incrementing write and read-back
        page = 4'd3;
        incr_en = 1'b1;
        wframe(8'h10, 3, 8'h21);
        rframe(8'h10, 3, "R6");
        // R5: non-incrementing
        incr_en = 1'b0;
        wframe(8'h20, 2, 8'h5A);
        rframe(8'h20, 2, "R5");
        // R5: wrap inside page
        incr_en = 1'b1;
        wframe(8'h7F, 2, 8'h90);
        rframe(8'h7F, 2, "R5");
        // R3: page selects upper address bits
        page = 4'd9;
        wframe(8'h10, 1, 8'hC3);
        rframe(8'h10, 1, "R3");
        page = 4'd3;
        rframe(8'h10, 1, "R3");
        // R8: reselect inside recovery pause is ignored
        sel();
        xfer(8'h30, rx);
        wait_rdy();
        exp_addr.push_back((3 << 7) | 8'h30);
        exp_data.push_back(8'h77);
        xfer(8'h77, rx);
        wait_rdy();
        ssel_n = 1'b1;
        tick(1);
        ssel_n = 1'b0;
        tick(8);
        xfer(8'h31, rx);
        wait_rdy();
        xfer(8'h66, rx);
        wait_rdy();
        chk(spi_err == 0, "R8", "ignored frame no error", spi_err, 0);
        desel_check();
        // R9: clock during read gap
        sel();
        xfer(8'h90, rx);
        xfer(8'hFF, rx);
        tick(1);
        chk(spi_err == 1, "R9", "err after early clock", spi_err, 1);
        chk(rdy == 0, "R9", "rdy low with error", rdy, 0);
        rc = rd_cnt;
        tick(20);
        xfer(8'hFF, rx);
        tick(20);
        chk(rd_cnt == rc, "R9", "no read after fault", rd_cnt, rc);
        ssel_n = 1'b1;
        tick(4);
        chk(spi_err == 1, "R9", "err held until pause ends", spi_err, 1);
        wait_rdy();
        chk(spi_err == 0, "R9", "err cleared", spi_err, 0);
        // R10: partial byte at deselect
        sel();
        xfer(8'h40, rx);
        wait_rdy();
        exp_addr.push_back((3 << 7) | 8'h40);
        exp_data.push_back(8'h3C);
        xfer(8'h3C, rx);
        wait_rdy();
        for (int i = 0; i < 3; i++) begin
            mosi = 1'b1;
            tick(HALF);
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
        end
        tick(2);
        ssel_n = 1'b1;
        tick(4);
        chk(spi_err == 1, "R10", "err on partial byte", spi_err, 1);
        wait_rdy();
        chk(spi_err == 0, "R10", "err cleared", spi_err, 0);
        chk(mem[(3 << 7) | 8'h41] == 8'((((3 << 7) | 8'h41) * 7 + 3) & 8'hFF),
            "R10", "no partial write", mem[(3 << 7) | 8'h41],
            (((3 << 7) | 8'h41) * 7 + 3) & 8'hFF);
        tick(10);
        chk(exp_addr.size() == 0, "R4", "all writes seen", exp_addr.size(), 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule